// File: doc/BRIEF.md
# Flash Controller Key-Locked Register Bank

This block is the register bank of a flash-interface controller. A simple synchronous bus writes and reads it. It holds an interface configuration word and a timing word. Neither can be changed unless a 16-bit key has been written to the key register first. The key opens exactly one protected write, and the lock then closes again by itself. The configuration and timing values drive the rest of the controller directly through output ports.

The bank also collects events from the rest of the controller into a latched interrupt status register. These events are rising edges of the flash-ready and controller-ready levels, decode failure, decode error, ECC ready, and refused protected writes. A mask register selects which latched bits raise the single level-high interrupt line. Reading the status register returns its contents and clears them. A live status register shows the two ready levels as they are now.

Register select (`bus_addr`): 0 configuration, 1 timing, 2 key, 3 interrupt mask, 4 latched interrupt status, 5 live status. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.

Top module: `flash_regbank`

## Requirements
- R1: After reset the configuration, mask and latched status are zero, the timing word equals its reset parameter, the bank is locked, and `irq` is low.
- R2: A write of 0xA25E (low 16 bits of `bus_wdata`) to the key register (select 2) unlocks the bank, and the next write to the configuration (select 0) or timing (select 1) register takes effect.
- R3: After one accepted protected write the bank locks again, so a second protected write without a new key is ignored.
- R4: A protected write while locked leaves the register unchanged and sets latched status bit 0 (write-protect fault).
- R5: A key write of any value other than 0xA25E leaves the bank locked, or locks it again if it was open.
- R6: Latched status bits hold until read. Bit 5 is set by a rising edge of `flash_ready`, bit 4 by a rising edge of `ctrl_ready`, bit 3 by `ev_dec_fail`, bit 2 by `ev_dec_err`, bit 1 by `ev_ecc_rdy`, and bit 0 by a refused write.
- R7: A read of select 4 returns the latched status and clears every bit of it.
- R8: An event in the same cycle as a status read is not lost. It is missing from that read and present in the next one.
- R9: `irq` is high exactly when some latched bit is set whose mask bit (select 3, same bit layout, 6 bits) is also set.
- R10: The live status register (select 5) shows `flash_ready` in bit 0 and `ctrl_ready` in bit 1. `dev_ready` is high only when both are high.
- R11: Configuration (bits 3:0: write-protect, large block, 5-byte address, 16-bit bus), timing and mask read back their stored values. The key register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flash_ready | input | 1 | Flash device ready level |
| ctrl_ready | input | 1 | Controller ready level |
| ev_dec_fail | input | 1 | Decode failure pulse |
| ev_dec_err | input | 1 | Decode error (corrected) pulse |
| ev_ecc_rdy | input | 1 | ECC ready pulse |
| irq | output | 1 | Level-high interrupt |
| cfg_out | output | 4 | Interface configuration |
| timing_out | output | TIM_W | Timing word |
| dev_ready | output | 1 | Both ready levels high |

## Verification
The in-line assertions check several properties on every cycle. The lock closes after each accepted protected write. A correct key opens it. A refused write raises the fault bit and leaves the configuration untouched. Latched bits persist until a read. A read clears the status while keeping any event that arrives in the same cycle. The interrupt stays low with no mask bit set. Some behaviour only the bench scenarios can show: the exact values read back, one-shot use of a single key across a sequence of writes, relocking by a wrong key, the interrupt tracking mask changes, and edge-only capture of the ready levels.

// File: rtl/flashreg_pkg.sv
package flashreg_pkg;

    localparam int SEL_W  = 3;
    localparam int IRQ_N  = 6;
    localparam int KEY_W  = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG  = 3'd0,
        SEL_TIM  = 3'd1,
        SEL_KEY  = 3'd2,
        SEL_MASK = 3'd3,
        SEL_IRQ  = 3'd4,
        SEL_LIVE = 3'd5
    } reg_sel_e;

    // Shared bit layout of mask and latched status
    typedef struct packed {
        logic flash_rdy;   // 5
        logic ctrl_rdy;    // 4
        logic dec_fail;    // 3
        logic dec_err;     // 2
        logic ecc_rdy;     // 1
        logic wp_fault;    // 0
    } irq_vec_t;

    typedef struct packed {
        logic wprot;       // 3
        logic big_block;   // 2
        logic addr5;       // 1
        logic wide_bus;    // 0
    } iface_cfg_t;

    function automatic logic is_guarded(input reg_sel_e s);
        return (s == SEL_CFG) || (s == SEL_TIM);
    endfunction

endpackage

// File: rtl/key_lock.sv
module key_lock
    import flashreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             prot_wr,
    output logic             unlocked,
    output logic             prot_accept,
    output logic             prot_reject
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (key_wr)
            open_q <= (key_val == UNLOCK_KEY);
        else if (prot_wr)
            open_q <= 1'b0;
    end

    assign unlocked    = open_q;
    assign prot_accept = prot_wr & open_q;
    assign prot_reject = prot_wr & ~open_q;

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        prot_accept |=> !unlocked); // R3
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_val == UNLOCK_KEY) |=> unlocked); // R2
    AST_BAD_KEY_SHUTS: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_val != UNLOCK_KEY) |=> !unlocked); // R5

endmodule

// File: rtl/level_rise.sv
module level_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/irq_latch.sv
module irq_latch
    import flashreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_vec,
    input  logic     rd_clr,
    input  logic     mask_wr,
    input  irq_vec_t mask_din,
    output irq_vec_t status,
    output irq_vec_t mask,
    output logic     irq
);
    irq_vec_t stat_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (rd_clr ? irq_vec_t'('0) : stat_q) | set_vec;
            if (mask_wr) mask_q <= mask_din;
        end
    end

    assign status = stat_q;
    assign mask   = mask_q;
    assign irq    = |(stat_q & mask_q);

    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (rst)
        set_vec.wp_fault |=> status.wp_fault); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && set_vec == '0) |=> (status == '0)); // R7
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (status == $past(set_vec))); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((status & $past(status)) == $past(status))); // R6
    AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R9

endmodule

// File: rtl/flash_regbank.sv
module flash_regbank
    import flashreg_pkg::*;
#(
    parameter int              TIM_W   = 32,
    parameter logic [TIM_W-1:0] TIM_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             flash_ready,
    input  logic             ctrl_ready,
    input  logic             ev_dec_fail,
    input  logic             ev_dec_err,
    input  logic             ev_ecc_rdy,
    output logic             irq,
    output logic [3:0]       cfg_out,
    output logic [TIM_W-1:0] timing_out,
    output logic             dev_ready
);
    localparam int CFG_W = $bits(iface_cfg_t);

    reg_sel_e   sel;
    logic       key_wr, prot_wr, unlocked, prot_accept, prot_reject;
    logic [1:0] rise;
    irq_vec_t   events, status, mask;
    iface_cfg_t cfg_q;
    logic [TIM_W-1:0] tim_q;
    logic [31:0] rd_mux, rdata_q;

    assign sel     = reg_sel_e'(bus_addr);
    assign key_wr  = bus_wr && (sel == SEL_KEY);
    assign prot_wr = bus_wr && is_guarded(sel);

    key_lock u_lock (
        .clk(clk), .rst(rst), .key_wr(key_wr), .key_val(bus_wdata[KEY_W-1:0]),
        .prot_wr(prot_wr), .unlocked(unlocked),
        .prot_accept(prot_accept), .prot_reject(prot_reject)
    );

    level_rise #(.N(2)) u_rise (
        .clk(clk), .rst(rst), .lvl({ctrl_ready, flash_ready}), .rise(rise)
    );

    always_comb begin
        events           = '0;
        events.flash_rdy = rise[0];
        events.ctrl_rdy  = rise[1];
        events.dec_fail  = ev_dec_fail;
        events.dec_err   = ev_dec_err;
        events.ecc_rdy   = ev_ecc_rdy;
        events.wp_fault  = prot_reject;
    end

    irq_latch u_irq (
        .clk(clk), .rst(rst), .set_vec(events),
        .rd_clr(bus_rd && (sel == SEL_IRQ)),
        .mask_wr(bus_wr && (sel == SEL_MASK)),
        .mask_din(irq_vec_t'(bus_wdata[IRQ_N-1:0])),
        .status(status), .mask(mask), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tim_q <= TIM_RST;
        end else if (prot_accept) begin
            if (sel == SEL_CFG) cfg_q <= iface_cfg_t'(bus_wdata[CFG_W-1:0]);
            else                tim_q <= bus_wdata[TIM_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CFG:  rd_mux[CFG_W-1:0] = cfg_q;
            SEL_TIM:  rd_mux[TIM_W-1:0] = tim_q;
            SEL_MASK: rd_mux[IRQ_N-1:0] = mask;
            SEL_IRQ:  rd_mux[IRQ_N-1:0] = status;
            SEL_LIVE: rd_mux[1:0]       = {ctrl_ready, flash_ready};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign cfg_out    = cfg_q;
    assign timing_out = tim_q;
    assign dev_ready  = flash_ready & ctrl_ready;

    AST_LOCKED_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_CFG && !unlocked) |=> $stable(cfg_out)); // R4
    AST_LOCKED_TIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_TIM && !unlocked) |=> $stable(timing_out)); // R4
    AST_OPEN_CFG_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_CFG && unlocked) |=> (cfg_out == $past(bus_wdata[3:0]))); // R2

endmodule

// File: tb/flash_regbank_bench.sv
module flash_regbank_bench;
    localparam int TIM_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic flash_ready = 1'b0, ctrl_ready = 1'b0;
    logic ev_dec_fail = 1'b0, ev_dec_err = 1'b0, ev_ecc_rdy = 1'b0;
    logic irq, dev_ready;
    logic [3:0] cfg_out;
    logic [TIM_W-1:0] timing_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_regbank u_flash_regbank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_ready(flash_ready), .ctrl_ready(ctrl_ready),
        .ev_dec_fail(ev_dec_fail), .ev_dec_err(ev_dec_err), .ev_ecc_rdy(ev_ecc_rdy),
        .irq(irq), .cfg_out(cfg_out), .timing_out(timing_out), .dev_ready(dev_ready)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares read data with the expected queue
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && !rst) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
            end else
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic clear_bus();
        bus_wr = 0; bus_rd = 0; ev_dec_fail = 0; ev_dec_err = 0; ev_ecc_rdy = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); clear_bus();
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag,
                      input logic [2:0] ev = 3'b000);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1; bus_addr = a;
        {ev_dec_fail, ev_dec_err, ev_ecc_rdy} = ev;
        @(negedge clk); clear_bus();
    endtask

    task automatic pulse(input logic [2:0] ev);
        {ev_dec_fail, ev_dec_err, ev_ecc_rdy} = ev;
        @(negedge clk); clear_bus();
    endtask

    task automatic levels(input logic f, input logic c);
        flash_ready = f; ctrl_ready = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(cfg_out, 0, "R1 cfg");
        check(timing_out, 0, "R1 timing");
        check(irq, 0, "R1 irq");
        rd(3'd4, 32'h0, "R1 status");
        rd(3'd3, 32'h0, "R1 mask");
        // R4 locked write refused, fault latched
        wr(3'd0, 32'hF);
        check(cfg_out, 0, "R4 cfg unchanged");
        rd(3'd4, 32'h01, "R4 fault bit");
        rd(3'd4, 32'h00, "R7 cleared");
        // R2 key opens one write
        wr(3'd2, 32'h0000A25E);
        wr(3'd0, 32'h6);
        check(cfg_out, 4'h6, "R2 cfg written");
        rd(3'd0, 32'h6, "R11 cfg readback");
        rd(3'd4, 32'h0, "R2 no fault");
        // R3 relock after one write
        wr(3'd0, 32'h9);
        check(cfg_out, 4'h6, "R3 second write ignored");
        rd(3'd4, 32'h01, "R3 fault on relocked");
        // R5 wrong key
        wr(3'd2, 32'h00001234);
        wr(3'd1, 32'h0000DEAD);
        check(timing_out, 0, "R5 wrong key stays locked");
        wr(3'd2, 32'h0000A25E);
        wr(3'd2, 32'h00000000);
        wr(3'd1, 32'h0000BEEF);
        check(timing_out, 0, "R5 wrong key relocks");
        rd(3'd4, 32'h01, "R5 fault latched");
        wr(3'd2, 32'hFFFFA25E);
        wr(3'd1, 32'h01234567);
        check(timing_out, 32'h01234567, "R2 timing written");
        rd(3'd1, 32'h01234567, "R11 timing readback");
        rd(3'd2, 32'h0, "R11 key reads zero");
        // R9 masking
        wr(3'd3, 32'h04);
        rd(3'd3, 32'h04, "R11 mask readback");
        pulse(3'b100);
        check(irq, 0, "R9 unmasked fail no irq");
        pulse(3'b010);
        check(irq, 1, "R9 masked err raises irq");
        rd(3'd4, 32'h0C, "R6 fail+err held");
        check(irq, 0, "R9 irq drops after clear");
        // R6 ready edges, R10 live status
        levels(1, 0);
        levels(1, 1);
        check(dev_ready, 1, "R10 both ready");
        rd(3'd4, 32'h30, "R6 ready edges");
        rd(3'd5, 32'h3, "R10 live both");
        levels(1, 0);
        check(dev_ready, 0, "R10 one ready");
        rd(3'd5, 32'h1, "R10 live flash only");
        rd(3'd4, 32'h0, "R6 no event on level hold/fall");
        // R8 event during read
        wr(3'd3, 32'h02);
        rd(3'd4, 32'h0, "R8 read with event", 3'b001);
        check(irq, 1, "R8 event kept raises irq");
        rd(3'd4, 32'h02, "R8 event kept");
        check(irq, 0, "R7 cleared irq low");
        repeat (2) @(negedge clk);
        check(exp_q.size(), 0, "scoreboard drained");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule